// File: doc/BRIEF.md
# Soft-Decision Depuncturer with Alignment Search

The block sits in front of a rate 1/2 convolutional decoder that has two generator outputs. It takes pairs of 4-bit soft values (an I value and a Q value) from a punctured channel stream. It puts each received value back into its place in the mother-code sequence. Every position that the transmitter dropped is filled with a neutral soft value and marked with an erasure flag. The output is one soft value, plus its erasure flag, for each generator per output pair.

The receiver does not know where the puncture period starts, or whether the I and Q rails are swapped. The block finds this out by itself. It tries each pattern offset and then the swapped rail order. For each candidate it collects a decoder health pulse (for example a path-metric renormalisation or a detected error) over a window of output pairs of programmable length. A window is good when its pulse count is below a threshold. The first good window asserts the lock output. While locked, a programmable number of bad windows in a row drops lock, and the search continues with the next candidate. Writing a new code rate restarts the whole procedure.

Top module: `vit_depuncturer`

## Requirements
- R1: While rst_ni is low and right after it rises, out_valid_o and lock_o are 0.
- R2: rate_i selects the code rate and the pattern period P = rate_i+1. The codes 0..7 stand for 1/2, 2/3, 3/4, 4/5, 5/6, 6/7, 7/8 and 8/9. Column c of the period keeps generator 1 when bit c of the G1 mask is 1, and keeps generator 2 when bit c of the G2 mask is 1. The G1 masks per code are 01,01,05,01,15,29,51,81 (hex). The G2 masks per code are 01,03,03,0F,0B,17,2F,7F (hex). Output pairs walk the columns in order. Each kept position takes the next received value: g1 takes one before g2, and within an input pair I comes before Q.
- R3: An erased position gives value 0 with its erasure flag at 1. No output pair has both flags set.
- R4: When the swap candidate is active, an input pair is taken in the order Q then I.
- R5: Input pairs arrive at most every other cycle. An input captured at edge E can give an output pair at edge E+1 at the earliest, and does so when the buffer held no earlier values.
- R6: A window spans dwell_i output pairs. It counts the cycles with bad_i high, and is good when that count is below thresh_i.
- R7: While unlocked, each bad window moves to the next candidate. The offset steps 0..P-1, and after P-1 the offset returns to 0 and the I/Q order toggles. Output pair j since the last restart uses column (j + offset) mod P.
- R8: lock_o rises at the end of the first good window.
- R9: While locked, lock_o falls after miss_lim_i bad windows in a row, and a good window clears that run. On the fall the search moves to the next candidate.
- R10: A change of rate_i clears lock_o, the candidate, the column and all buffered values, in the cycle after the change. An input in that cycle is discarded.
- R11: The value buffer never overflows when inputs respect the pacing of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_i | input | 3 | Code rate select (0 = 1/2 ... 7 = 8/9) |
| in_valid_i | input | 1 | Input soft pair valid |
| i_soft_i | input | 4 | Soft I value |
| q_soft_i | input | 4 | Soft Q value |
| bad_i | input | 1 | Decoder health pulse, high for one bad event |
| dwell_i | input | 8 | Window length in output pairs |
| thresh_i | input | 8 | Bad-event count at which a window is bad |
| miss_lim_i | input | 3 | Bad windows in a row that drop lock |
| out_valid_o | output | 1 | Output pair valid |
| g1_o | output | 4 | Soft value for generator 1 |
| g2_o | output | 4 | Soft value for generator 2 |
| g1_era_o | output | 1 | Generator 1 position erased |
| g2_era_o | output | 1 | Generator 2 position erased |
| lock_o | output | 1 | Alignment found |

## Verification
An input pair captured at an edge can leave as an output pair one edge later. Lock changes and candidate changes are registered at the same edge as the pair that closes the window. A rate change takes effect at the next edge. The bench therefore records every output pair at the falling edge into a log. It then checks the log against a model of pair index, column and offset, so it does not need to guess exact cycles in streaming runs. Single-cycle checks (the latency, the lock clearing on a rate change, the lock after a window) sample at the falling edge that follows the edge where the result is due.

// File: rtl/depunct_pkg.sv
package depunct_pkg;
  localparam int unsigned MAX_PERIOD = 8;
  typedef logic [2:0] rate_t;
  typedef logic [MAX_PERIOD-1:0] mask_t;

  // bit c = column c of the period kept
  function automatic mask_t keep_g1(rate_t r);
    case (r)
      3'd0: keep_g1 = 8'h01;
      3'd1: keep_g1 = 8'h01;
      3'd2: keep_g1 = 8'h05;
      3'd3: keep_g1 = 8'h01;
      3'd4: keep_g1 = 8'h15;
      3'd5: keep_g1 = 8'h29;
      3'd6: keep_g1 = 8'h51;
      default: keep_g1 = 8'h81;
    endcase
  endfunction

  function automatic mask_t keep_g2(rate_t r);
    case (r)
      3'd0: keep_g2 = 8'h01;
      3'd1: keep_g2 = 8'h03;
      3'd2: keep_g2 = 8'h03;
      3'd3: keep_g2 = 8'h0F;
      3'd4: keep_g2 = 8'h0B;
      3'd5: keep_g2 = 8'h17;
      3'd6: keep_g2 = 8'h2F;
      default: keep_g2 = 8'h7F;
    endcase
  endfunction
endpackage

// File: rtl/depunct_fifo.sv
module depunct_fifo #(
  parameter int unsigned SW    = 4,
  parameter int unsigned DEPTH = 6,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [SW-1:0] d0_i,
  input  logic [SW-1:0] d1_i,
  input  logic [1:0]    pop_i,
  output logic [SW-1:0] head0_o,
  output logic [SW-1:0] head1_o,
  output logic [CW-1:0] cnt_o
);
  logic [SW-1:0] q_q  [DEPTH];
  logic [SW-1:0] nq   [DEPTH];
  logic [SW-1:0] ext  [DEPTH+2];
  logic [CW-1:0] cnt_q, ncnt, cnt_d;

  always_comb begin
    for (int i = 0; i < DEPTH + 2; i++) ext[i] = (i < DEPTH) ? q_q[i] : '0;
    ncnt = cnt_q - CW'(pop_i);
    for (int i = 0; i < DEPTH; i++) begin
      case (pop_i)
        2'd0:    nq[i] = ext[i];
        2'd1:    nq[i] = ext[i+1];
        default: nq[i] = ext[i+2];
      endcase
      if (push_i && CW'(i) == ncnt)          nq[i] = d0_i;
      if (push_i && CW'(i) == ncnt + CW'(1)) nq[i] = d1_i;
    end
    cnt_d = push_i ? ncnt + CW'(2) : ncnt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) q_q[i] <= '0;
    end else if (flush_i) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) q_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) q_q[i] <= nq[i];
    end
  end

  assign head0_o = q_q[0];
  assign head1_o = q_q[1];
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/depunct_search.sv
module depunct_search #(
  parameter int unsigned DW = 8,
  parameter int unsigned TW = 8,
  parameter int unsigned MW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          fire_i,
  input  logic          bad_i,
  input  logic [3:0]    period_i,
  input  logic [DW-1:0] dwell_i,
  input  logic [TW-1:0] thresh_i,
  input  logic [MW-1:0] miss_lim_i,
  output logic [2:0]    phase_o,
  output logic          swap_o,
  output logic          lock_o
);
  logic [DW-1:0] wcnt_q;
  logic [TW-1:0] ecnt_q, e_inc;
  logic [MW-1:0] miss_q;
  logic [2:0]    phase_q;
  logic          swap_q, lock_q;
  logic [TW:0]   total;
  logic          win_end, good, drop, step;

  always_comb begin
    win_end = fire_i && (({1'b0, wcnt_q} + (DW+1)'(1)) >= {1'b0, dwell_i});
    total   = {1'b0, ecnt_q} + (TW+1)'(bad_i);
    good    = total < {1'b0, thresh_i};
    e_inc   = (ecnt_q == '1) ? ecnt_q : ecnt_q + TW'(bad_i);
    drop    = ({1'b0, miss_q} + (MW+1)'(1)) >= {1'b0, miss_lim_i};
    step    = win_end && !good && (!lock_q || drop);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0; ecnt_q <= '0; miss_q <= '0;
      phase_q <= '0; swap_q <= 1'b0; lock_q <= 1'b0;
    end else if (restart_i) begin
      wcnt_q <= '0; ecnt_q <= '0; miss_q <= '0;
      phase_q <= '0; swap_q <= 1'b0; lock_q <= 1'b0;
    end else begin
      if (fire_i) wcnt_q <= win_end ? '0 : wcnt_q + DW'(1);
      ecnt_q <= win_end ? '0 : e_inc;
      if (win_end) begin
        if (good) begin
          lock_q <= 1'b1;
          miss_q <= '0;
        end else if (lock_q) begin
          if (drop) begin
            lock_q <= 1'b0;
            miss_q <= '0;
          end else begin
            miss_q <= miss_q + MW'(1);
          end
        end
      end
      if (step) begin
        if ({1'b0, phase_q} == period_i - 4'd1) begin
          phase_q <= '0;
          swap_q  <= ~swap_q;
        end else begin
          phase_q <= phase_q + 3'd1;
        end
      end
    end
  end

  assign phase_o = phase_q;
  assign swap_o  = swap_q;
  assign lock_o  = lock_q;
endmodule

// File: rtl/vit_depuncturer.sv
module vit_depuncturer
  import depunct_pkg::*;
#(
  parameter int unsigned SW    = 4,
  parameter int unsigned DW    = 8,
  parameter int unsigned TW    = 8,
  parameter int unsigned MW    = 3,
  parameter int unsigned DEPTH = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    rate_i,
  input  logic          in_valid_i,
  input  logic [SW-1:0] i_soft_i,
  input  logic [SW-1:0] q_soft_i,
  input  logic          bad_i,
  input  logic [DW-1:0] dwell_i,
  input  logic [TW-1:0] thresh_i,
  input  logic [MW-1:0] miss_lim_i,
  output logic          out_valid_o,
  output logic [SW-1:0] g1_o,
  output logic [SW-1:0] g2_o,
  output logic          g1_era_o,
  output logic          g2_era_o,
  output logic          lock_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  rate_t         rate_q;
  logic          restart, fire, push, swap, kx, ky;
  logic [3:0]    period, col_sum;
  logic [2:0]    col_q, col_eff, phase;
  logic [1:0]    need, pop;
  logic [CW-1:0] buf_cnt;
  logic [SW-1:0] head0, head1, d0, d1;
  mask_t         mx, my;

  always_comb begin
    restart = rate_i != rate_q;
    period  = {1'b0, rate_q} + 4'd1;
    col_sum = {1'b0, col_q} + {1'b0, phase};
    col_eff = (col_sum >= period) ? 3'(col_sum - period) : 3'(col_sum);
    mx      = keep_g1(rate_q);
    my      = keep_g2(rate_q);
    kx      = mx[col_eff];
    ky      = my[col_eff];
    need    = {1'b0, kx} + {1'b0, ky};
    fire    = !restart && (buf_cnt >= CW'(need));
    pop     = fire ? need : 2'd0;
    push    = in_valid_i && !restart;
    d0      = swap ? q_soft_i : i_soft_i;
    d1      = swap ? i_soft_i : q_soft_i;
  end

  depunct_fifo #(.SW(SW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .flush_i(restart), .push_i(push), .d0_i(d0), .d1_i(d1),
    .pop_i(pop), .head0_o(head0), .head1_o(head1), .cnt_o(buf_cnt)
  );

  depunct_search #(.DW(DW), .TW(TW), .MW(MW)) u_search (
    .clk_i, .rst_ni, .restart_i(restart), .fire_i(fire), .bad_i,
    .period_i(period), .dwell_i, .thresh_i, .miss_lim_i,
    .phase_o(phase), .swap_o(swap), .lock_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= '0; col_q <= '0; out_valid_o <= 1'b0;
      g1_o <= '0; g2_o <= '0; g1_era_o <= 1'b0; g2_era_o <= 1'b0;
    end else begin
      rate_q      <= rate_i;
      out_valid_o <= fire;
      if (restart) begin
        col_q <= '0;
      end else if (fire) begin
        col_q    <= ({1'b0, col_q} == period - 4'd1) ? '0 : col_q + 3'd1;
        g1_o     <= kx ? head0 : '0;
        g2_o     <= ky ? (kx ? head1 : head0) : '0;
        g1_era_o <= !kx;
        g2_era_o <= !ky;
      end
    end
  end
endmodule

// File: rtl/depunct_checker.sv
module depunct_checker #(
  parameter int unsigned SW    = 4,
  parameter int unsigned DEPTH = 6,
  parameter int unsigned CW    = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic [2:0]    rate_i,
  input logic [2:0]    rate_q,
  input logic [CW-1:0] buf_cnt,
  input logic [1:0]    pop,
  input logic          out_valid_o,
  input logic [SW-1:0] g1_o,
  input logic [SW-1:0] g2_o,
  input logic          g1_era_o,
  input logic          g2_era_o,
  input logic          lock_o
);
  p_era_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ((!g1_era_o || g1_o == '0) && (!g2_era_o || g2_o == '0)));

  p_one_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !(g1_era_o && g2_era_o));

  p_no_overflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && rate_i == rate_q) |-> ({1'b0, buf_cnt} + 2 <= {1'b0, CW'(DEPTH)} + {2'b0, pop}));

  p_rate_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_i != rate_q) |=> (!lock_o && !out_valid_o));

  p_lock_at_window_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> out_valid_o);

  p_pair_has_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(buf_cnt) != '0);
endmodule

bind vit_depuncturer depunct_checker #(.SW(SW), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i, .rst_ni, .in_valid_i, .rate_i, .rate_q, .buf_cnt, .pop,
  .out_valid_o, .g1_o, .g2_o, .g1_era_o, .g2_era_o, .lock_o
);

// File: tb/vit_depuncturer_test.sv
`timescale 1ns/1ps
module vit_depuncturer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] rate = 3'd0;
  logic in_valid = 1'b0, bad = 1'b0, bad_hold = 1'b0;
  logic [3:0] si = '0, sq = '0;
  logic [7:0] dwell = 8'd200, thresh = 8'd1;
  logic [2:0] miss_lim = 3'd2;
  logic out_valid, e1, e2, lock;
  logic [3:0] g1, g2;
  int checks = 0, errors = 0, idx = 0;

  // stimulus: rate code; expected: {G1 mask, G2 mask}
  localparam logic [15:0] PAT [8] = '{16'h0101, 16'h0103, 16'h0503, 16'h010F,
                                      16'h150B, 16'h2917, 16'h512F, 16'h817F};

  logic [3:0] m_g1 [1024];
  logic [3:0] m_g2 [1024];
  logic       m_e1 [1024];
  logic       m_e2 [1024];

  always #2 clk = ~clk;

  vit_depuncturer uut (
    .clk_i(clk), .rst_ni(rst_n), .rate_i(rate), .in_valid_i(in_valid),
    .i_soft_i(si), .q_soft_i(sq), .bad_i(bad), .dwell_i(dwell), .thresh_i(thresh),
    .miss_lim_i(miss_lim), .out_valid_o(out_valid), .g1_o(g1), .g2_o(g2),
    .g1_era_o(e1), .g2_era_o(e2), .lock_o(lock)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid && idx < 1024) begin
      m_g1[idx] = g1; m_g2[idx] = g2; m_e1[idx] = e1; m_e2[idx] = e2;
      idx = idx + 1;
    end
  end

  function automatic int ival(int s); return (s * 3 + 1) % 16; endfunction
  function automatic int qval(int s); return (s * 5 + 2) % 16; endfunction
  function automatic int sval(int p); return (p % 2 == 0) ? ival(p / 2) : qval(p / 2); endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(int a, int b, logic b_lvl);
    @(posedge clk); #1;
    in_valid = 1'b1; si = 4'(a); sq = 4'(b); bad = b_lvl;
    @(posedge clk); #1;
    in_valid = 1'b0; bad = bad_hold;
  endtask

  task automatic set_rate(int r);
    @(posedge clk); #1 rate = 3'(r);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base, ptr, j, n, c, kx, ky, nd, ph, sw;
    logic [7:0] xm, ym;
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 valid in reset", int'(out_valid), 0);
    chk("R1 lock in reset", int'(lock), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", int'(out_valid), 0);
    chk("R1 lock after reset", int'(lock), 0);

    // R2 R3 table walk over all rates
    for (int r = 0; r < 8; r++) begin
      set_rate(r);
      base = idx;
      for (int s = 0; s < 24; s++) send(ival(s), qval(s), 1'b0);
      settle();
      xm = PAT[r][15:8]; ym = PAT[r][7:0];
      ptr = 0; j = 0;
      while (1) begin
        c = j % (r + 1);
        kx = int'(xm[c]); ky = int'(ym[c]); nd = kx + ky;
        if (ptr + nd > 48) break;
        chk("R3 g1 erasure flag", int'(m_e1[base+j]), 1 - kx);
        chk("R3 g2 erasure flag", int'(m_e2[base+j]), 1 - ky);
        chk("R2 g1 value", int'(m_g1[base+j]), kx ? sval(ptr) : 0);
        chk("R2 g2 value", int'(m_g2[base+j]), ky ? sval(ptr + kx) : 0);
        ptr += nd; j++;
      end
      chk("R2 pair count", idx - base, j);
    end

    // R5 latency
    set_rate(0);
    in_valid = 1'b1; si = 4'd5; sq = 4'd9;
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    chk("R5 no pair at capture edge", int'(out_valid), 0);
    @(negedge clk);
    chk("R5 pair one edge later", int'(out_valid), 1);
    chk("R5 g1 value", int'(g1), 5);
    chk("R5 g2 value", int'(g2), 9);

    // R8 lock after first good window
    dwell = 8'd4; thresh = 8'd1;
    set_rate(1);
    send(ival(0), qval(0), 1'b0);
    send(ival(1), qval(1), 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R8 no lock before window end", int'(lock), 0);
    for (int s = 2; s < 10; s++) send(ival(s), qval(s), 1'b0);
    settle();
    chk("R8 lock after good window", int'(lock), 1);

    // R10 rate change while locked
    @(posedge clk); #1 rate = 3'd6;
    @(posedge clk); @(negedge clk);
    chk("R10 lock cleared", int'(lock), 0);
    chk("R10 no output", int'(out_valid), 0);
    base = idx;
    for (int s = 0; s < 4; s++) send(ival(s), qval(s), 1'b0);
    settle();
    chk("R10 first pair g1 era", int'(m_e1[base]), 0);
    chk("R10 first pair g1 fresh", int'(m_g1[base]), ival(0));
    chk("R10 second pair g1 era", int'(m_e1[base+1]), 1);
    chk("R10 second pair g2 value", int'(m_g2[base+1]), ival(1));

    // R7 search order under constant bad feedback, rate 3/4
    dwell = 8'd3; thresh = 8'd1;
    bad_hold = 1'b1; bad = 1'b1;
    set_rate(2);
    base = idx;
    for (int s = 0; s < 30; s++) send(ival(s), qval(s), 1'b1);
    settle();
    n = idx - base;
    chk("R7 enough pairs", int'(n >= 30), 1);
    for (int q = 0; q < n; q++) begin
      ph = (q / 3) % 3;
      c = (q + ph) % 3;
      chk("R7 g1 era by offset", int'(m_e1[base+q]), 1 - int'(PAT[2][8+c]));
      chk("R7 g2 era by offset", int'(m_e2[base+q]), 1 - int'(PAT[2][c]));
    end
    chk("R7 stays unlocked", int'(lock), 0);

    // R4 rail swap at rate 1/2
    dwell = 8'd2;
    set_rate(0);
    base = idx;
    for (int s = 0; s < 12; s++) send(ival(s), qval(s), 1'b1);
    settle();
    for (int s = 0; s < 12; s++) begin
      sw = (s / 2) % 2;
      chk("R4 g1 order", int'(m_g1[base+s]), sw ? qval(s) : ival(s));
      chk("R4 g2 order", int'(m_g2[base+s]), sw ? ival(s) : qval(s));
    end
    bad_hold = 1'b0; bad = 1'b0;

    // R9 lock loss after consecutive bad windows
    dwell = 8'd2; thresh = 8'd1; miss_lim = 3'd2;
    set_rate(1);
    set_rate(0);
    base = idx;
    send(ival(0), qval(0), 1'b0); send(ival(1), qval(1), 1'b0);
    send(ival(2), qval(2), 1'b1); send(ival(3), qval(3), 1'b1);
    send(ival(4), qval(4), 1'b0); send(ival(5), qval(5), 1'b0);
    send(ival(6), qval(6), 1'b1); send(ival(7), qval(7), 1'b1);
    @(posedge clk); @(negedge clk);
    chk("R9 single bad windows keep lock", int'(lock), 1);
    send(ival(8), qval(8), 1'b1); send(ival(9), qval(9), 1'b1);
    @(posedge clk); @(negedge clk);
    chk("R9 lock dropped", int'(lock), 0);
    send(ival(10), qval(10), 1'b0);
    settle();
    chk("R9 search resumed g1", int'(m_g1[base+10]), qval(10));
    chk("R9 search resumed g2", int'(m_g2[base+10]), ival(10));

    // R6 threshold compare
    thresh = 8'd3;
    set_rate(1);
    set_rate(0);
    send(ival(0), qval(0), 1'b1); send(ival(1), qval(1), 1'b1);
    settle();
    chk("R6 count below threshold locks", int'(lock), 1);
    thresh = 8'd2;
    set_rate(1);
    set_rate(0);
    send(ival(0), qval(0), 1'b1); send(ival(1), qval(1), 1'b1);
    settle();
    chk("R6 count at threshold no lock", int'(lock), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule